// File: doc/BRIEF.md
# Control Symbol Error Checker

This block sits on the receive side of a packet link and screens every aligned control-symbol word before the link logic acts on it. An aligned word carries a 16-bit symbol in its upper half and the bitwise inverse of that symbol in its lower half. The checker confirms that the two halves are exact complements. It then checks the inverted-parity bit that guards the symbol/packet marker. For acknowledge symbols (accepted, retry, not-accepted) it compares the symbol against the transmitter's outstanding-packet state: the number of packets awaiting acknowledge and the identifier of the oldest of them.

A pulse from the transmitter's acknowledge timer counts as an unexpected-identifier error, just as an acknowledge with the wrong identifier would. Each detected fault raises exactly one registered error flag and a single recoverable-error event. It also advances a per-type saturating counter. Software-facing logic reads the counters, clears them one by one with write-one-to-clear strobes, and receives an interrupt once any counter rises strictly above a programmable threshold. Recovery sequencing and retransmission are handled elsewhere.

Field layout of the true half (bits 31:16 of the received word, numbered here as bits 15:0 of that half): bit 15 marker S, bit 14 inverted parity P of S, bits 13:11 symbol kind, bits 10:8 acknowledge identifier, bits 7:0 unchecked contents.

Top module: `ctl_symbol_checker`

## Requirements
- R1: A valid word whose lower 16 bits are not the exact bitwise inverse of its upper 16 bits raises the corrupt flag (err_flags bit 0), whatever the fields hold.
- R2: A valid word with matching halves, S=1 and P=1 raises the parity flag (err_flags bit 1).
- R3: A valid word with matching halves, S=0 and P=0 cannot be classed as a symbol or a packet and raises the corrupt flag; S=0 with P=1 is a packet header and raises no flag.
- R4: A clean symbol (S=1, P=0) of kind 000, 001 or 010 (the three acknowledges) arriving while out_count is 0 raises the unsolicited flag (err_flags bit 2).
- R5: A clean acknowledge arriving while out_count is nonzero raises the unexpected-identifier flag (err_flags bit 3) when its identifier differs from out_head, and no flag when it matches; kinds 011 to 111 never raise a flag.
- R6: An ack_timeout pulse while out_count is nonzero raises the unexpected-identifier flag. With out_count 0 it has no effect. When the same cycle's word raises a flag of its own, only that flag is reported.
- R7: Flags appear on the clock edge after the word is sampled and last one cycle; at most one flag is set, and rec_err is high exactly when one is.
- R8: Counter i (err_count bits i*CNT_W upward) adds one for each cycle flag i is raised and holds at all ones once reached.
- R9: A 1 on cnt_clear bit i zeroes counter i on the next edge and takes precedence over an increment in the same cycle.
- R10: irq goes high one edge after any counter holds a value strictly greater than thresh and is low while every counter is at or below thresh.
- R11: Synchronous reset clears the flags, rec_err, every counter and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | rx_word holds a received aligned word this cycle |
| rx_word | input | 2*SYM_W | True half in the upper bits, complement half in the lower bits |
| out_count | input | ID_W | Number of packets awaiting acknowledge (0 to 7) |
| out_head | input | ID_W | Identifier of the oldest packet awaiting acknowledge |
| ack_timeout | input | 1 | Acknowledge timer expired for an outstanding packet |
| thresh | input | CNT_W | Interrupt threshold for the counters |
| cnt_clear | input | 4 | Write-one-to-clear strobes, one per counter |
| err_flags | output | 4 | One-hot error flags: 0 corrupt, 1 parity, 2 unsolicited, 3 unexpected identifier |
| rec_err | output | 1 | Recoverable-error event |
| err_count | output | 4*CNT_W | Saturating per-type counters, counter i at bits i*CNT_W upward |
| irq | output | 1 | Threshold interrupt |

## Verification
A misclassification inside the decode or acknowledge comparison shows at err_flags on the very next edge, so the bench sweeps every kind, identifier, outstanding count and head value. It also flips each of the 32 word bits and runs all four marker/parity combinations, with timeouts both alone and colliding with word errors. A wrong counter state shows in err_count on that same edge and in irq one edge later. Counter and interrupt expectations are therefore kept by arithmetic in the bench and compared after every word, with threshold runs that stop exactly at the threshold and one step past it.

// File: rtl/csym_pkg.sv
package csym_pkg;
  localparam int NUM_ERR     = 4;
  localparam int ERR_CORRUPT = 0;
  localparam int ERR_SPAR    = 1;
  localparam int ERR_UNSOL   = 2;
  localparam int ERR_BADID   = 3;

  localparam int TYPE_W = 3;
  localparam logic [TYPE_W-1:0] KIND_ACCEPT = 3'd0;
  localparam logic [TYPE_W-1:0] KIND_RETRY  = 3'd1;
  localparam logic [TYPE_W-1:0] KIND_NACK   = 3'd2;
endpackage

// File: rtl/csym_word_decode.sv
module csym_word_decode
  import csym_pkg::*;
#(
  parameter int SYM_W = 16,
  parameter int ID_W  = 3
) (
  input  logic               valid,
  input  logic [2*SYM_W-1:0] word,
  output logic               corrupt,
  output logic               spar,
  output logic               is_ack,
  output logic [ID_W-1:0]    ack_id
);
  localparam int S_POS  = SYM_W - 1;
  localparam int P_POS  = SYM_W - 2;
  localparam int TY_HI  = SYM_W - 3;
  localparam int TY_LO  = SYM_W - 2 - TYPE_W;
  localparam int ID_HI  = TY_LO - 1;
  localparam int ID_LO  = TY_LO - ID_W;

  logic [SYM_W-1:0]  t_half;
  logic [SYM_W-1:0]  c_half;
  logic              halves_ok;
  logic              s_bit;
  logic              p_bit;
  logic              ctl_ok;
  logic [TYPE_W-1:0] kind;

  assign t_half    = word[2*SYM_W-1:SYM_W];
  assign c_half    = word[SYM_W-1:0];
  assign halves_ok = ((t_half ^ c_half) == {SYM_W{1'b1}});
  assign s_bit     = t_half[S_POS];
  assign p_bit     = t_half[P_POS];
  assign kind      = t_half[TY_HI:TY_LO];
  assign ack_id    = t_half[ID_HI:ID_LO];

  always_comb begin
    corrupt = 1'b0;
    spar    = 1'b0;
    ctl_ok  = 1'b0;
    if (valid) begin
      if (!halves_ok) begin
        corrupt = 1'b1;
      end else if (!s_bit && !p_bit) begin
        corrupt = 1'b1;           // marker unreadable: neither symbol nor packet
      end else if (s_bit && p_bit) begin
        spar = 1'b1;
      end else if (s_bit) begin
        ctl_ok = 1'b1;
      end
    end
  end

  assign is_ack = ctl_ok &&
                  (kind == KIND_ACCEPT || kind == KIND_RETRY || kind == KIND_NACK);
endmodule

// File: rtl/csym_ack_check.sv
module csym_ack_check #(
  parameter int ID_W = 3
) (
  input  logic            is_ack,
  input  logic [ID_W-1:0] ack_id,
  input  logic [ID_W-1:0] out_count,
  input  logic [ID_W-1:0] out_head,
  input  logic            timeout,
  input  logic            word_fault,
  output logic            unsol,
  output logic            badid
);
  logic pending;
  logic badid_word;
  logic badid_tmo;

  assign pending    = (out_count != '0);
  assign unsol      = is_ack && !pending;
  assign badid_word = is_ack && pending && (ack_id != out_head);
  // a timer expiry yields to any fault the word itself carries
  assign badid_tmo  = timeout && pending && !word_fault && !unsol && !badid_word;
  assign badid      = badid_word || badid_tmo;
endmodule

// File: rtl/csym_sat_counter.sv
module csym_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && cnt != CNT_MAX) begin
      cnt <= cnt + CNT_ONE;
    end
  end

  assert_sat_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

  assert_step_R8: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + CNT_ONE);

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);
endmodule

// File: rtl/ctl_symbol_checker.sv
module ctl_symbol_checker
  import csym_pkg::*;
#(
  parameter int SYM_W = 16,
  parameter int ID_W  = 3,
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rx_valid,
  input  logic [2*SYM_W-1:0]       rx_word,
  input  logic [ID_W-1:0]          out_count,
  input  logic [ID_W-1:0]          out_head,
  input  logic                     ack_timeout,
  input  logic [CNT_W-1:0]         thresh,
  input  logic [NUM_ERR-1:0]       cnt_clear,
  output logic [NUM_ERR-1:0]       err_flags,
  output logic                     rec_err,
  output logic [NUM_ERR*CNT_W-1:0] err_count,
  output logic                     irq
);
  logic               dec_corrupt;
  logic               dec_spar;
  logic               dec_is_ack;
  logic [ID_W-1:0]    dec_ack_id;
  logic               chk_unsol;
  logic               chk_badid;
  logic [NUM_ERR-1:0] nxt_flags;
  logic [NUM_ERR-1:0] above;

  csym_word_decode #(.SYM_W(SYM_W), .ID_W(ID_W)) u_decode (
    .valid   (rx_valid),
    .word    (rx_word),
    .corrupt (dec_corrupt),
    .spar    (dec_spar),
    .is_ack  (dec_is_ack),
    .ack_id  (dec_ack_id)
  );

  csym_ack_check #(.ID_W(ID_W)) u_ack (
    .is_ack     (dec_is_ack),
    .ack_id     (dec_ack_id),
    .out_count  (out_count),
    .out_head   (out_head),
    .timeout    (ack_timeout),
    .word_fault (dec_corrupt || dec_spar),
    .unsol      (chk_unsol),
    .badid      (chk_badid)
  );

  always_comb begin
    nxt_flags              = '0;
    nxt_flags[ERR_CORRUPT] = dec_corrupt;
    nxt_flags[ERR_SPAR]    = dec_spar;
    nxt_flags[ERR_UNSOL]   = chk_unsol;
    nxt_flags[ERR_BADID]   = chk_badid;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ERR; gi++) begin : g_cnt
      csym_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (nxt_flags[gi]),
        .clr (cnt_clear[gi]),
        .cnt (err_count[gi*CNT_W +: CNT_W])
      );
      assign above[gi] = (err_count[gi*CNT_W +: CNT_W] > thresh);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flags <= '0;
      rec_err   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      err_flags <= nxt_flags;
      rec_err   <= |nxt_flags;
      irq       <= |above;
    end
  end

  // ---------------- assertions ----------------
  assert_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(err_flags));

  assert_event_R7: assert property (@(posedge clk) disable iff (rst)
    rec_err == (err_flags != '0));

  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !ack_timeout) |=> err_flags == '0);

  assert_corrupt_R1: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && ((rx_word[2*SYM_W-1:SYM_W] ^ rx_word[SYM_W-1:0]) != {SYM_W{1'b1}}))
    |=> (err_flags[ERR_CORRUPT] && rec_err));

  assert_unsol_R4: assert property (@(posedge clk) disable iff (rst)
    (dec_is_ack && out_count == '0) |=> err_flags[ERR_UNSOL]);

  assert_idle_timer_R6: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && ack_timeout && out_count == '0) |=> !rec_err);
endmodule

// File: tb/ctl_symbol_checker_test.sv
module ctl_symbol_checker_test;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_valid = 1'b0;
  logic [31:0]   rx_word = '0;
  logic [2:0]    out_count = '0;
  logic [2:0]    out_head = '0;
  logic          ack_timeout = 1'b0;
  logic [CW-1:0] thresh = '1;
  logic [3:0]    cnt_clear = '0;
  logic [3:0]    err_flags;
  logic          rec_err;
  logic [4*CW-1:0] err_count;
  logic          irq;

  int errors = 0;
  int checks = 0;
  int exp_cnt [4];

  always #2 clk = ~clk;

  ctl_symbol_checker #(.SYM_W(16), .ID_W(3), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_word(rx_word),
    .out_count(out_count), .out_head(out_head), .ack_timeout(ack_timeout),
    .thresh(thresh), .cnt_clear(cnt_clear), .err_flags(err_flags),
    .rec_err(rec_err), .err_count(err_count), .irq(irq)
  );

  function automatic logic [31:0] mkword(bit s, bit p, logic [2:0] kind,
                                         logic [2:0] id, logic [7:0] rest);
    logic [15:0] t;
    t = {s, p, kind, id, rest};
    return {t, ~t};
  endfunction

  function automatic logic [3:0] model(bit v, logic [31:0] w, logic [2:0] n,
                                       logic [2:0] h, bit tmo);
    logic [15:0] t;
    logic [15:0] c;
    logic [3:0]  r;
    t = w[31:16];
    c = w[15:0];
    r = 4'b0000;
    if (v) begin
      if ((t ^ c) != 16'hFFFF || (!t[15] && !t[14])) r = 4'b0001;
      else if (t[15] && t[14])                        r = 4'b0010;
      else if (t[15] && t[13:11] <= 3'd2) begin
        if (n == 3'd0)          r = 4'b0100;
        else if (t[10:8] != h)  r = 4'b1000;
      end
    end
    if (r == 4'b0000 && tmo && n != 3'd0) r = 4'b1000;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_counts(string tag);
    for (int i = 0; i < 4; i++)
      chk(tag, 32'(err_count[i*CW +: CW]), 32'(exp_cnt[i]));
  endtask

  task automatic apply(bit v, logic [31:0] w, logic [2:0] n, logic [2:0] h,
                       bit tmo, logic [3:0] clr, string tag);
    logic [3:0] e;
    @(negedge clk);
    rx_valid = v; rx_word = w; out_count = n; out_head = h;
    ack_timeout = tmo; cnt_clear = clr;
    e = model(v, w, n, h, tmo);
    @(posedge clk);
    #1;
    chk({tag, " flags"}, 32'(err_flags), 32'(e));
    chk("R7 rec_err", 32'(rec_err), 32'(e != 4'b0000));
    for (int i = 0; i < 4; i++) begin
      if (clr[i]) exp_cnt[i] = 0;
      else if (e[i] && exp_cnt[i] < (1 << CW) - 1) exp_cnt[i]++;
    end
    check_counts("R8 counters");
    rx_valid = 1'b0; ack_timeout = 1'b0; cnt_clear = '0;
  endtask

  task automatic idle_irq(string tag);
    bit any;
    any = 1'b0;
    @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++) if (exp_cnt[i] > int'(thresh)) any = 1'b1;
    chk(tag, 32'(irq), 32'(any));
    chk("R7 flags one cycle", 32'(err_flags), 32'(0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) exp_cnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    // R11: reset state
    chk("R11 flags", 32'(err_flags), 32'(0));
    chk("R11 rec_err", 32'(rec_err), 32'(0));
    chk("R11 irq", 32'(irq), 32'(0));
    check_counts("R11 counters");

    // R4 / R5: every kind, identifier, outstanding count and head
    for (int k = 0; k < 8; k++)
      for (int id = 0; id < 8; id++)
        for (int n = 0; n < 8; n++)
          for (int h = 0; h < 8; h++)
            apply(1'b1, mkword(1'b1, 1'b0, 3'(k), 3'(id), 8'(k*37 + n*5 + h)),
                  3'(n), 3'(h), 1'b0, 4'b0000, "R4/R5 ack sweep");
    idle_irq("R10 irq stays low at max threshold");

    // R9: clear every counter
    apply(1'b0, '0, 3'd0, 3'd0, 1'b0, 4'b1111, "R9 clear all");

    // R1: every single-bit flip of an otherwise matching acknowledge
    for (int b = 0; b < 32; b++)
      apply(1'b1, mkword(1'b1, 1'b0, 3'd0, 3'd2, 8'h5A) ^ (32'd1 << b),
            3'd1, 3'd2, 1'b0, 4'b0000, "R1 bit flip");

    // R2 / R3: marker and parity combinations with matching halves
    for (int sp = 0; sp < 4; sp++)
      for (int n = 0; n < 2; n++)
        apply(1'b1, mkword(sp[1], sp[0], 3'd1, 3'd4, 8'hC3), 3'(n), 3'd4,
              1'b0, 4'b0000, "R2/R3 marker");

    // R6: timer expiry alone, and colliding with words
    for (int n = 0; n < 8; n++) begin
      apply(1'b0, '0, 3'(n), 3'd3, 1'b1, 4'b0000, "R6 timeout alone");
      apply(1'b1, mkword(1'b1, 1'b0, 3'd2, 3'd3, 8'h00) ^ 32'h1, 3'(n), 3'd3,
            1'b1, 4'b0000, "R6 timeout with corrupt");
      apply(1'b1, mkword(1'b1, 1'b1, 3'd0, 3'd3, 8'h00), 3'(n), 3'd3,
            1'b1, 4'b0000, "R6 timeout with parity");
      apply(1'b1, mkword(1'b1, 1'b0, 3'd0, 3'd3, 8'h11), 3'(n), 3'd3,
            1'b1, 4'b0000, "R6 timeout with good ack");
      apply(1'b1, mkword(1'b1, 1'b0, 3'd5, 3'd7, 8'h11), 3'(n), 3'd3,
            1'b1, 4'b0000, "R6 timeout with other kind");
    end

    // R9: clear collides with an increment
    apply(1'b1, 32'h0000_0000, 3'd0, 3'd0, 1'b0, 4'b0001, "R9 clear beats corrupt");
    apply(1'b1, mkword(1'b1, 1'b1, 3'd0, 3'd0, 8'h0), 3'd0, 3'd0, 1'b0, 4'b0010,
          "R9 clear beats parity");

    // R10: threshold crossing
    @(negedge clk);
    thresh = 4'd3;
    apply(1'b0, '0, 3'd0, 3'd0, 1'b0, 4'b1111, "R10 clear");
    idle_irq("R10 irq low after clear");
    for (int i = 0; i < 3; i++)
      apply(1'b1, mkword(1'b1, 1'b0, 3'd1, 3'd0, 8'h0), 3'd0, 3'd0, 1'b0,
            4'b0000, "R10 unsolicited run");
    idle_irq("R10 irq low at threshold");
    apply(1'b1, mkword(1'b1, 1'b0, 3'd1, 3'd0, 8'h0), 3'd0, 3'd0, 1'b0,
          4'b0000, "R10 unsolicited over");
    idle_irq("R10 irq high above threshold");
    apply(1'b0, '0, 3'd0, 3'd0, 1'b0, 4'b0100, "R9 clear unsolicited");
    idle_irq("R10 irq drops after clear");
    for (int i = 0; i < 20; i++)
      apply(1'b0, '0, 3'd6, 3'd1, 1'b1, 4'b0000, "R8 timeout saturation");
    idle_irq("R10 irq from identifier counter");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule